// File: doc/BRIEF.md
# Soft-Ramped Two-Channel Digital Volume

This block scales a two-channel stream of signed 24-bit audio samples by a per-channel 8-bit linear gain code. The gain that is applied does not jump to a newly requested code. It walks toward that code one step at a time, and the pace is set by the audio frame strobe. This keeps volume changes free of clicks.

The step interval depends on the sample-rate mode. Faster frame rates get proportionally more frames per step, so a ramp takes the same wall-clock time in every mode. A soft-mute input reuses the same ramp: it drives every channel toward zero. When it is released, the gain climbs back to the requested code, starting from wherever it was.

A surrounding controller supplies the target codes, the mode and the mute flag as levels. The sample path supplies one sample per channel and takes back the scaled value one clock later.

Top module: `soft_ramp_volume`

## Requirements
- R1: Each output equals floor(sample × m / 256), where m = code + 1 for codes 128..255 and m = code for codes 0..127, so that the result approximates sample × code / 255. Code 0 gives 0 and code 255 returns the sample unchanged. The output is registered and reflects the sample and the applied code present before the clock edge.
- R2: While rst_n is low, both outputs are 0. On release, both applied codes are 255 and the frame-pacing count is zero.
- R3: The applied code of a channel changes by exactly one code per step, always toward its goal. The goal is 0 while muteReq is high and the channel's target otherwise. The code changes only on a clock where frameTick is high.
- R4: A step fires on a frameTick when the number of frame strobes since the previous step (or since reset), including the current one, reaches the interval. The interval is 4 for speedSel = 00, 8 for 01 and 16 for 10 or 11. Strobes are counted whether or not any channel needs to move.
- R5: With mute held from reset, the applied code reaches 0 after exactly 1020, 2040 or 4080 frame strobes in the three speed modes. After one strobe fewer it is still nonzero.
- R6: While muteReq stays high, each applied code ramps down to 0 and stays there.
- R7: After muteReq falls, each applied code ramps up to its target and then holds it while the target is unchanged.
- R8: If muteReq falls before zero is reached, the ramp turns back toward the target from the present code, with no jump.
- R9: The two channels have separate targets and ramps. One channel reaching its goal does not stop or alter the other.
- R10: Changing a target during a ramp redirects the ramp toward the new goal and does not restart the frame-pacing count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frameTick | input | 1 | One-clock strobe per audio frame |
| speedSel | input | 2 | Sample-rate mode: 00 normal, 01 double, 10/11 quad |
| muteReq | input | 1 | Soft-mute request (level) |
| targetL | input | 8 | Requested gain code, left channel |
| targetR | input | 8 | Requested gain code, right channel |
| sampleL | input | 24 | Signed input sample, left channel |
| sampleR | input | 24 | Signed input sample, right channel |
| outL | output | 24 | Signed scaled sample, left channel |
| outR | output | 24 | Signed scaled sample, right channel |

## Verification
The assertions check on every clock that:
- an applied code never moves by more than one;
- an applied code moves only when a frame strobe was present;
- code 0 silences the output and code 255 passes the sample through unchanged;
- a muted channel at zero stays there;
- a channel that has settled on its target holds it.

Other behaviours need the bench's scenarios because they span many frames:
- the exact pacing count per speed mode, and the full-scale ramp durations;
- reversal of a half-finished mute;
- redirection of a ramp with the pacing count preserved;
- the two channels moving independently.

A scoreboard compares every output sample against the gain law in all of these scenarios.

// File: rtl/srvol_pkg.sv
package srvol_pkg;
  localparam int NUM_CH = 2;

  // One strobe pair per channel: move the applied code up or down by one.
  typedef struct packed {
    logic [NUM_CH-1:0] inc;
    logic [NUM_CH-1:0] dec;
  } gainStep_t;
endpackage

// File: rtl/srvol_ctrl.sv
module srvol_ctrl
  import srvol_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int BASE_FRAMES = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           frameTick,
  input  logic [1:0]                     speedSel,
  input  logic                           muteReq,
  input  logic [NUM_CH-1:0][CODE_W-1:0]  targetCode,
  input  logic [NUM_CH-1:0][CODE_W-1:0]  appliedCode,
  output gainStep_t                      stepCmd
);
  localparam int MAX_FRAMES = BASE_FRAMES * 4;
  localparam int CNT_W      = $clog2(MAX_FRAMES + 1);

  logic [CNT_W-1:0] frameCnt;
  logic [CNT_W-1:0] cntInc;
  logic [CNT_W-1:0] interval;
  logic             stepNow;

  always_comb begin
    case (speedSel)
      2'b00:   interval = CNT_W'(BASE_FRAMES);
      2'b01:   interval = CNT_W'(BASE_FRAMES * 2);
      default: interval = CNT_W'(MAX_FRAMES);
    endcase
  end

  assign cntInc  = frameCnt + 1'b1;
  // >= keeps the pacing sane when the mode shrinks the interval mid-count
  assign stepNow = frameTick && (cntInc >= interval);

  always_ff @(posedge clk) begin
    if (!rst_n)         frameCnt <= '0;
    else if (frameTick) frameCnt <= stepNow ? '0 : cntInc;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dir
    logic [CODE_W-1:0] goal;
    assign goal = muteReq ? '0 : targetCode[ch];
    assign stepCmd.inc[ch] = stepNow && (appliedCode[ch] < goal);
    assign stepCmd.dec[ch] = stepNow && (appliedCode[ch] > goal);
  end
endmodule

// File: rtl/srvol_datapath.sv
module srvol_datapath
  import srvol_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CODE_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  gainStep_t                      stepCmd,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  sampleIn,
  output logic [NUM_CH-1:0][CODE_W-1:0]  appliedCode,
  output logic [NUM_CH-1:0][DATA_W-1:0]  scaledOut
);
  localparam int MULT_W = CODE_W + 1;
  localparam int PROD_W = DATA_W + MULT_W + 1;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    logic [CODE_W-1:0]        gainQ;
    logic [DATA_W-1:0]        outQ;
    logic [MULT_W-1:0]        effMult;
    logic signed [PROD_W-1:0] product;

    always_ff @(posedge clk) begin
      if (!rst_n)                gainQ <= '1;
      else if (stepCmd.inc[ch])  gainQ <= gainQ + 1'b1;
      else if (stepCmd.dec[ch])  gainQ <= gainQ - 1'b1;
    end

    // Upper half of the code range gets +1 so full scale maps to 2^CODE_W.
    assign effMult = {1'b0, gainQ} + MULT_W'(gainQ[CODE_W-1]);
    assign product = PROD_W'($signed(sampleIn[ch])) * PROD_W'($signed({1'b0, effMult}));

    always_ff @(posedge clk) begin
      if (!rst_n) outQ <= '0;
      else        outQ <= DATA_W'(product >>> CODE_W);
    end

    assign appliedCode[ch] = gainQ;
    assign scaledOut[ch]   = outQ;
  end
endmodule

// File: rtl/soft_ramp_volume.sv
module soft_ramp_volume
  import srvol_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int CODE_W      = 8,
  parameter int BASE_FRAMES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameTick,
  input  logic [1:0]        speedSel,
  input  logic              muteReq,
  input  logic [CODE_W-1:0] targetL,
  input  logic [CODE_W-1:0] targetR,
  input  logic [DATA_W-1:0] sampleL,
  input  logic [DATA_W-1:0] sampleR,
  output logic [DATA_W-1:0] outL,
  output logic [DATA_W-1:0] outR
);
  logic [NUM_CH-1:0][CODE_W-1:0] targetCode;
  logic [NUM_CH-1:0][CODE_W-1:0] appliedCode;
  logic [NUM_CH-1:0][DATA_W-1:0] sampleIn;
  logic [NUM_CH-1:0][DATA_W-1:0] scaledOut;
  gainStep_t                     stepCmd;

  assign targetCode = {targetR, targetL};
  assign sampleIn   = {sampleR, sampleL};
  assign outL       = scaledOut[0];
  assign outR       = scaledOut[1];

  srvol_ctrl #(.CODE_W(CODE_W), .BASE_FRAMES(BASE_FRAMES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frameTick(frameTick), .speedSel(speedSel),
    .muteReq(muteReq), .targetCode(targetCode), .appliedCode(appliedCode),
    .stepCmd(stepCmd)
  );

  srvol_datapath #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stepCmd(stepCmd), .sampleIn(sampleIn),
    .appliedCode(appliedCode), .scaledOut(scaledOut)
  );
endmodule

// File: rtl/soft_ramp_volume_chk.sv
module soft_ramp_volume_chk #(
  parameter int DATA_W = 24,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frameTick,
  input logic              muteReq,
  input logic [CODE_W-1:0] targetL,
  input logic [CODE_W-1:0] gainL,
  input logic [CODE_W-1:0] gainR,
  input logic [DATA_W-1:0] sampleL,
  input logic [DATA_W-1:0] outL,
  input logic [DATA_W-1:0] outR
);
  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gainL != $past(gainL)) |->
      ($past(frameTick) && ((gainL == $past(gainL) + 1) || (gainL == $past(gainL) - 1))));

  // R3
  right_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gainR != $past(gainR)) |-> $past(frameTick));

  // R1
  zero_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gainR == '0) |=> (outR == '0));

  // R1
  unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gainL == '1) |=> (outL == $past(sampleL)));

  // R6
  mute_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (muteReq && gainL == '0) |=> (gainL == '0));

  // R7
  target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!muteReq && gainL == targetL) |=> (gainL == $past(targetL)));
endmodule

bind soft_ramp_volume soft_ramp_volume_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frameTick(frameTick), .muteReq(muteReq),
  .targetL(targetL), .gainL(appliedCode[0]), .gainR(appliedCode[1]),
  .sampleL(sampleL), .outL(outL), .outR(outR)
);

// File: tb/soft_ramp_volume_tb.sv
`timescale 1ns/1ps
module soft_ramp_volume_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frameTick = 1'b0;
  logic [1:0]        speedSel = 2'b00;
  logic              muteReq = 1'b0;
  logic [7:0]        targetL = 8'hFF;
  logic [7:0]        targetR = 8'hFF;
  logic [23:0]       sampleL = '0;
  logic [23:0]       sampleR = '0;
  logic [23:0]       outL;
  logic [23:0]       outR;

  always #2.5 clk = ~clk;

  soft_ramp_volume u_dut (
    .clk(clk), .rst_n(rst_n), .frameTick(frameTick), .speedSel(speedSel),
    .muteReq(muteReq), .targetL(targetL), .targetR(targetR),
    .sampleL(sampleL), .sampleR(sampleR), .outL(outL), .outR(outR)
  );

  typedef struct {
    logic [23:0] eL;
    logic [23:0] eR;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int checks = 0;
  int fails  = 0;
  int mGainL = 255, mGainR = 255, mCnt = 0;

  task automatic chk(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Gain law of R1: floor(s*m/256), m = code (+1 when code >= 128)
  function automatic logic [23:0] refScale(logic [23:0] s, int g);
    longint p;
    int m;
    m = g + ((g >= 128) ? 1 : 0);
    p = longint'($signed(s)) * m;
    return 24'(p >>> 8);
  endfunction

  function automatic int toward(int g, int goal);
    if (g < goal) return g + 1;
    if (g > goal) return g - 1;
    return g;
  endfunction

  function automatic logic [23:0] rs();
    int sel;
    sel = int'($urandom_range(0, 7));
    if (sel == 0) return 24'h7FFFFF;
    if (sel == 1) return 24'h800000;
    return 24'($urandom);
  endfunction

  // Monitor: pops one expectation per clock after the edge
  always @(posedge clk) begin : mon
    exp_t e;
    #2;
    if (sbq.size() > 0) begin
      e = sbq.pop_front();
      chk(outL === e.eL, {e.tag, " left"},  longint'($signed(outL)), longint'($signed(e.eL)));
      chk(outR === e.eR, {e.tag, " right"}, longint'($signed(outR)), longint'($signed(e.eR)));
    end
  end

  // Driver: applies one clock of stimulus and predicts its result
  task automatic drive(bit fr, logic [1:0] sp, logic [7:0] tl, logic [7:0] tr, bit mu,
                       logic [23:0] sl, logic [23:0] sr, string tag);
    exp_t e;
    int lim;
    @(negedge clk);
    frameTick = fr; speedSel = sp; targetL = tl; targetR = tr;
    muteReq = mu; sampleL = sl; sampleR = sr;
    e.eL = refScale(sl, mGainL);
    e.eR = refScale(sr, mGainR);
    e.tag = tag;
    sbq.push_back(e);
    lim = (sp == 2'b00) ? 4 : (sp == 2'b01) ? 8 : 16;
    if (fr) begin
      if (mCnt + 1 >= lim) begin
        mCnt = 0;
        mGainL = toward(mGainL, mu ? 0 : int'(tl));
        mGainR = toward(mGainR, mu ? 0 : int'(tr));
      end else begin
        mCnt++;
      end
    end
  endtask

  task automatic run(int n, int every, logic [1:0] sp, logic [7:0] tl, logic [7:0] tr,
                     bit mu, string tag);
    for (int i = 0; i < n; i++)
      drive((i % every) == every - 1, sp, tl, tr, mu, rs(), rs(), tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    frameTick = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R2: outputs held at zero in reset
    chk(outL == '0, "R2 reset left",  longint'(outL), 0);
    chk(outR == '0, "R2 reset right", longint'(outR), 0);
    mGainL = 255; mGainR = 255; mCnt = 0;
    rst_n = 1'b1;
  endtask

  // R5: full-scale mute ramp length in frames
  task automatic rampTime(logic [1:0] sp, int frames, string tag);
    doReset();
    for (int i = 0; i < frames - 1; i++)
      drive(1'b1, sp, 8'hFF, 8'hFF, 1'b1, 24'h400000, 24'h400000, tag);
    drive(1'b0, sp, 8'hFF, 8'hFF, 1'b1, 24'h400000, 24'h400000, tag);
    drive(1'b0, sp, 8'hFF, 8'hFF, 1'b1, 24'h400000, 24'h400000, tag);
    @(posedge clk); #1;
    chk(outL == 24'h004000, {tag, " one frame short"}, longint'(outL), 24'h004000);
    drive(1'b1, sp, 8'hFF, 8'hFF, 1'b1, 24'h400000, 24'h400000, tag);
    drive(1'b0, sp, 8'hFF, 8'hFF, 1'b1, 24'h400000, 24'h400000, tag);
    drive(1'b0, sp, 8'hFF, 8'hFF, 1'b1, 24'h400000, 24'h400000, tag);
    @(posedge clk); #1;
    chk(outL == '0, {tag, " reached zero"}, longint'(outL), 0);
  endtask

  initial begin : watchdog
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    doReset();
    // R1 R2: unity after reset, no frames
    drive(1'b0, 2'b00, 8'hFF, 8'hFF, 1'b0, 24'h7FFFFF, 24'h800000, "R1 R2 unity extremes");
    drive(1'b0, 2'b00, 8'hFF, 8'hFF, 1'b0, 24'h000001, 24'hFFFFFF, "R1 R2 unity small");
    run(20, 1, 2'b00, 8'h40, 8'hC0, 1'b0, "R1 R2 no frame held");
    // R3 R4 R9: separate targets, normal speed, frame every clock
    run(900, 1, 2'b00, 8'h40, 8'hC0, 1'b0, "R3 R4 R9 normal ramp");
    // R4: double speed, sparse frames, one channel rising
    run(600, 3, 2'b01, 8'hA0, 8'h10, 1'b0, "R4 double sparse");
    // R4: speed 11 behaves as quad
    run(400, 2, 2'b11, 8'h30, 8'h90, 1'b0, "R4 quad alias");
    // R8: mute partway, then release before zero
    run(300, 1, 2'b00, 8'hE0, 8'h90, 1'b1, "R8 mute partial");
    run(500, 1, 2'b00, 8'hE0, 8'h90, 1'b0, "R8 reverse toward target");
    // R6: mute to the floor and hold
    run(2000, 1, 2'b00, 8'hE0, 8'h90, 1'b1, "R6 mute to zero");
    // R7: release and settle on target
    run(2000, 1, 2'b00, 8'hE0, 8'h90, 1'b0, "R7 release to target");
    // R10: redirect mid-ramp without restarting pacing
    run(150, 1, 2'b00, 8'h00, 8'h90, 1'b0, "R10 ramp down");
    run(7, 2, 2'b00, 8'h00, 8'h90, 1'b0, "R10 odd phase");
    run(200, 1, 2'b00, 8'hFF, 8'h20, 1'b0, "R10 redirected");
    @(negedge clk); frameTick = 1'b0;
    rampTime(2'b00, 1020, "R5 normal");
    rampTime(2'b01, 2040, "R5 double");
    rampTime(2'b10, 4080, "R5 quad");
    @(negedge clk); frameTick = 1'b0;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule